// File: doc/BRIEF.md
# Power Mode and Output Priority Controller

This controller turns a two-bit standby setting, an output-override bit and a reference-buffer power-down bit into the enables for the analog domains and the drive mode of a digital output word. The output word is resolved by a fixed three-level priority:

- Total shutdown forces the word low.
- Otherwise, the override bit forces live data.
- Otherwise, reference standby freezes the word at its last value.
- Normal operation always passes live data.

The block also tracks whether the timing core may be trusted. The core is marked invalid when the chip enters total shutdown or when the input clock is disturbed. Software brings it back by writing 0 and then 1 to a core-reset bit. After the chip leaves total shutdown, that second write must come at least a parameterised number of microsecond ticks after the standby write. A write that comes too early sets a sticky error flag instead of validating the core.

The standby setting is captured by a write strobe. Other register bits are levels. A one-cycle pulse reports a clock disturbance, and a free-running microsecond tick times the wait.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The standby code 2'b00 selects normal operation: `core_en`=1, `ref_en`=1, `out_mode`=2'b00 (drive), and `data_out` follows `data_in`.
- R2: The standby code 2'b01 selects reference standby: `core_en`=0 and `ref_en`=1.
- R3: The standby codes 2'b10 and 2'b11 select total shutdown: `core_en`=0, `ref_en`=0, `refbuf_en`=0, `out_mode`=2'b10 (low) and `data_out`=0, whatever the value of `out_force`.
- R4: In reference standby with `out_force`=1, `out_mode`=2'b00 and `data_out` follows `data_in`. With `out_force`=0, `out_mode`=2'b01 (hold) and `data_out` keeps its previous value.
- R5: `refbuf_en` equals `ref_en` AND NOT `refbuf_pd`.
- R6: While `rst` is high, the block is in its reset state: the captured mode is normal operation, all enables are 0, `out_mode`=2'b10, `data_out`=0, `core_valid`=0 and `seq_err`=0.
- R7: A core-reset write of 1 that follows a core-reset write of 0 sets `core_valid` one cycle after the write. A core-reset write of 0 clears `core_valid`.
- R8: A core-reset write of 1 with no preceding 0 write has no effect on `core_valid`.
- R9: A `clk_disturb` pulse clears `core_valid` in the next cycle and discards any pending 0 write.
- R10: While the captured mode is total shutdown, `core_valid` is 0 and core-reset writes are ignored.
- R11: After a standby write that leaves total shutdown, a completing 1 write made before WAIT_TICKS `us_tick` cycles have passed sets `seq_err`, which stays set until reset, and leaves `core_valid` at 0. A sequence completed after that many ticks sets `core_valid`.
- R12: The enables, `out_mode` and `data_out` respond 2 cycles after a `stby_wr` strobe and 1 cycle after a change of `out_force`, `refbuf_pd` or `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_wr | input | 1 | Write strobe for the standby setting |
| stby_field | input | 2 | Standby setting value |
| out_force | input | 1 | Output override bit |
| refbuf_pd | input | 1 | Reference-buffer power-down bit |
| core_rst_wr | input | 1 | Write strobe for the core-reset bit |
| core_rst_bit | input | 1 | Value written to the core-reset bit |
| clk_disturb | input | 1 | Pulse: input clock interrupted or changed |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| data_in | input | DATA_W | Live digital output data |
| core_en | output | 1 | Analog core enable |
| ref_en | output | 1 | Reference enable |
| refbuf_en | output | 1 | Reference-buffer enable |
| out_mode | output | 2 | 00 drive, 01 hold, 10 low |
| data_out | output | DATA_W | Resolved digital output word |
| core_valid | output | 1 | Timing core trusted |
| seq_err | output | 1 | Sticky early-sequence error |

## Verification
A standby write is first captured in a mode register, and the output registers are loaded on the following edge. The output checks therefore sample on the falling edge after the second rising edge that follows the strobe, and one dedicated check confirms that the old mode is still present after only one edge. The level bits and the data word reach the outputs through one register, and `core_valid` and `seq_err` change on the edge that samples the core-reset write. Those checks sample on the falling edge right after that write. The wait-time check drives the tick on every cycle, so the tick count equals the cycle count since the standby write.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'b00,
    PM_REFSTBY = 2'b01,
    PM_OFF     = 2'b10
  } pmode_t;

  typedef enum logic [1:0] {
    OM_DRIVE = 2'b00,
    OM_HOLD  = 2'b01,
    OM_LOW   = 2'b10
  } omode_t;

  // Upper bit set means shutdown regardless of the lower bit
  function automatic pmode_t decode_field(input logic [1:0] fld);
    if (fld[1])      return PM_OFF;
    else if (fld[0]) return PM_REFSTBY;
    else             return PM_RUN;
  endfunction

endpackage

// File: rtl/pm_field_decode.sv
module pm_field_decode
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stby_wr,
  input  logic [1:0] stby_field,
  output pmode_t     mode_q,
  output logic       leave_off
);

  pmode_t mode_nxt;

  always_comb begin
    mode_nxt  = decode_field(stby_field);
    leave_off = stby_wr && (mode_q == PM_OFF) && (mode_nxt != PM_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= PM_RUN;
    else if (stby_wr) mode_q <= mode_nxt;
  end

endmodule

// File: rtl/pm_out_resolve.sv
module pm_out_resolve
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pmode_t            mode_q,
  input  logic              out_force,
  input  logic              refbuf_pd,
  input  logic [DATA_W-1:0] data_in,
  output logic              core_en,
  output logic              ref_en,
  output logic              refbuf_en,
  output omode_t            out_mode,
  output logic [DATA_W-1:0] data_out
);

  omode_t            om_nxt;
  logic              core_nxt;
  logic              ref_nxt;
  logic [DATA_W-1:0] dat_nxt;

  // Priority: shutdown > override bit > reference standby
  always_comb begin
    core_nxt = (mode_q == PM_RUN);
    ref_nxt  = (mode_q != PM_OFF);
    if (mode_q == PM_OFF)                      om_nxt = OM_LOW;
    else if (mode_q == PM_RUN || out_force)    om_nxt = OM_DRIVE;
    else                                       om_nxt = OM_HOLD;
    unique case (om_nxt)
      OM_LOW:   dat_nxt = '0;
      OM_HOLD:  dat_nxt = data_out;
      default:  dat_nxt = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en   <= 1'b0;
      ref_en    <= 1'b0;
      refbuf_en <= 1'b0;
      out_mode  <= OM_LOW;
      data_out  <= '0;
    end else begin
      core_en   <= core_nxt;
      ref_en    <= ref_nxt;
      refbuf_en <= ref_nxt && !refbuf_pd;
      out_mode  <= om_nxt;
      data_out  <= dat_nxt;
    end
  end

endmodule

// File: rtl/pm_core_seq.sv
module pm_core_seq
  import pwr_mode_pkg::*;
#(
  parameter int WAIT_TICKS = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  pmode_t mode_q,
  input  logic   leave_off,
  input  logic   core_rst_wr,
  input  logic   core_rst_bit,
  input  logic   clk_disturb,
  input  logic   us_tick,
  output logic   core_valid,
  output logic   seq_err
);

  localparam int CNT_W = $clog2(WAIT_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_TICKS);

  logic [CNT_W-1:0] tick_cnt;
  logic             wait_req;
  logic             armed;
  logic             wait_ok;

  assign wait_ok = !wait_req || (tick_cnt >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt   <= '0;
      wait_req   <= 1'b0;
      armed      <= 1'b0;
      core_valid <= 1'b0;
      seq_err    <= 1'b0;
    end else begin
      // Wait timer, restarted by the write that leaves shutdown
      if (leave_off) begin
        tick_cnt <= '0;
        wait_req <= 1'b1;
      end else if (us_tick && tick_cnt < LIMIT) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
      // Reset-sequence tracking
      if (mode_q == PM_OFF || clk_disturb) begin
        core_valid <= 1'b0;
        armed      <= 1'b0;
      end else if (core_rst_wr) begin
        if (!core_rst_bit) begin
          core_valid <= 1'b0;
          armed      <= 1'b1;
        end else if (armed) begin
          armed <= 1'b0;
          if (wait_ok) begin
            core_valid <= 1'b1;
            wait_req   <= 1'b0;
          end else begin
            seq_err <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WAIT_TICKS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_wr,
  input  logic [1:0]        stby_field,
  input  logic              out_force,
  input  logic              refbuf_pd,
  input  logic              core_rst_wr,
  input  logic              core_rst_bit,
  input  logic              clk_disturb,
  input  logic              us_tick,
  input  logic [DATA_W-1:0] data_in,
  output logic              core_en,
  output logic              ref_en,
  output logic              refbuf_en,
  output logic [1:0]        out_mode,
  output logic [DATA_W-1:0] data_out,
  output logic              core_valid,
  output logic              seq_err
);

  pmode_t mode_q;
  logic   leave_off;
  omode_t om;

  pm_field_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .stby_wr    (stby_wr),
    .stby_field (stby_field),
    .mode_q     (mode_q),
    .leave_off  (leave_off)
  );

  pm_out_resolve #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .out_force (out_force),
    .refbuf_pd (refbuf_pd),
    .data_in   (data_in),
    .core_en   (core_en),
    .ref_en    (ref_en),
    .refbuf_en (refbuf_en),
    .out_mode  (om),
    .data_out  (data_out)
  );

  assign out_mode = om;

  pm_core_seq #(.WAIT_TICKS(WAIT_TICKS)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .leave_off    (leave_off),
    .core_rst_wr  (core_rst_wr),
    .core_rst_bit (core_rst_bit),
    .clk_disturb  (clk_disturb),
    .us_tick      (us_tick),
    .core_valid   (core_valid),
    .seq_err      (seq_err)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              core_rst_wr,
  input logic              core_rst_bit,
  input logic              clk_disturb,
  input logic              core_en,
  input logic              ref_en,
  input logic              refbuf_en,
  input logic [1:0]        out_mode,
  input logic [DATA_W-1:0] data_out,
  input logic              core_valid,
  input logic              seq_err
);

  // R3
  low_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'b10) |-> (data_out == '0 && !core_en && !ref_en));

  // R5
  refbuf_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    refbuf_en |-> ref_en);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'b01) |=> (out_mode != 2'b01) || $stable(data_out));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  // R9
  disturb_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clk_disturb |=> !core_valid);

  // R7
  valid_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_valid) |-> $past(core_rst_wr && core_rst_bit));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .core_rst_wr  (core_rst_wr),
  .core_rst_bit (core_rst_bit),
  .clk_disturb  (clk_disturb),
  .core_en      (core_en),
  .ref_en       (ref_en),
  .refbuf_en    (refbuf_en),
  .out_mode     (out_mode),
  .data_out     (data_out),
  .core_valid   (core_valid),
  .seq_err      (seq_err)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stby_wr = 1'b0;
  logic [1:0]    stby_field = 2'b00;
  logic          out_force = 1'b0;
  logic          refbuf_pd = 1'b0;
  logic          core_rst_wr = 1'b0;
  logic          core_rst_bit = 1'b0;
  logic          clk_disturb = 1'b0;
  logic          us_tick = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          core_en, ref_en, refbuf_en, core_valid, seq_err;
  logic [1:0]    out_mode;
  logic [DW-1:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.DATA_W(DW), .WAIT_TICKS(100)) uut (
    .clk(clk), .rst(rst), .stby_wr(stby_wr), .stby_field(stby_field),
    .out_force(out_force), .refbuf_pd(refbuf_pd), .core_rst_wr(core_rst_wr),
    .core_rst_bit(core_rst_bit), .clk_disturb(clk_disturb), .us_tick(us_tick),
    .data_in(data_in), .core_en(core_en), .ref_en(ref_en), .refbuf_en(refbuf_en),
    .out_mode(out_mode), .data_out(data_out), .core_valid(core_valid),
    .seq_err(seq_err)
  );

  typedef struct packed {
    logic [1:0]    fld;
    logic          frc;
    logic          pd;
    logic [DW-1:0] din;
    logic          e_core;
    logic          e_ref;
    logic          e_buf;
    logic [1:0]    e_om;
    logic [DW-1:0] e_dout;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 1'b1, 2'd0, 8'hA5},
    '{2'b01, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 2'd0, 8'h3C},
    '{2'b01, 1'b0, 1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 2'd1, 8'h3C},
    '{2'b10, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},
    '{2'b11, 1'b0, 1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},
    '{2'b01, 1'b0, 1'b0, 8'h99, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00},
    '{2'b00, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 2'd0, 8'h5A},
    '{2'b01, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 2'd0, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stby_write(input logic [1:0] f);
    @(negedge clk);
    stby_field = f;
    stby_wr = 1'b1;
    @(negedge clk);
    stby_wr = 1'b0;
  endtask

  task automatic rst_write(input logic b);
    @(negedge clk);
    core_rst_bit = b;
    core_rst_wr = 1'b1;
    @(negedge clk);
    core_rst_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R6: reset state, sampled while reset is held
    repeat (3) @(negedge clk);
    chk("R6 core_valid", core_valid, 0);
    chk("R6 seq_err", seq_err, 0);
    chk("R6 out_mode", out_mode, 2'd2);
    chk("R6 data_out", data_out, 0);
    chk("R6 ref_en", ref_en, 0);
    chk("R6 refbuf_en", refbuf_en, 0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 decode and priority table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      out_force = VECS[i].frc;
      refbuf_pd = VECS[i].pd;
      data_in   = VECS[i].din;
      stby_field = VECS[i].fld;
      stby_wr = 1'b1;
      @(negedge clk);
      stby_wr = 1'b0;
      @(negedge clk);
      chk($sformatf("R1 R2 R3 core_en vec %0d", i), core_en, VECS[i].e_core);
      chk($sformatf("R2 R3 ref_en vec %0d", i), ref_en, VECS[i].e_ref);
      chk($sformatf("R5 refbuf_en vec %0d", i), refbuf_en, VECS[i].e_buf);
      chk($sformatf("R3 R4 out_mode vec %0d", i), out_mode, VECS[i].e_om);
      chk($sformatf("R1 R4 data_out vec %0d", i), data_out, VECS[i].e_dout);
    end

    // R12: output timing
    do_reset();
    out_force = 1'b0; refbuf_pd = 1'b0; data_in = 8'h21;
    repeat (2) @(negedge clk);
    stby_write(2'b01);
    chk("R12 one edge after stby_wr", out_mode, 2'd0);
    @(negedge clk);
    chk("R12 two edges after stby_wr", out_mode, 2'd1);
    out_force = 1'b1; data_in = 8'h44;
    @(negedge clk);
    chk("R12 out_force one edge", out_mode, 2'd0);
    chk("R12 data one edge", data_out, 8'h44);
    refbuf_pd = 1'b1;
    @(negedge clk);
    chk("R12 refbuf_pd one edge", refbuf_en, 0);

    // R8: 1 write without preceding 0
    do_reset();
    rst_write(1'b1);
    chk("R8 lone one write", core_valid, 0);

    // R7: ordered sequence
    rst_write(1'b0);
    chk("R7 after zero write", core_valid, 0);
    rst_write(1'b1);
    chk("R7 after one write", core_valid, 1);
    rst_write(1'b0);
    chk("R7 zero write clears", core_valid, 0);
    rst_write(1'b1);
    chk("R7 revalidate", core_valid, 1);

    // R9: clock disturbance
    @(negedge clk);
    clk_disturb = 1'b1;
    @(negedge clk);
    clk_disturb = 1'b0;
    chk("R9 disturb clears", core_valid, 0);
    rst_write(1'b0);
    @(negedge clk);
    clk_disturb = 1'b1;
    @(negedge clk);
    clk_disturb = 1'b0;
    rst_write(1'b1);
    chk("R9 pending zero discarded", core_valid, 0);
    rst_write(1'b0);
    rst_write(1'b1);
    chk("R9 recovery", core_valid, 1);

    // R10: shutdown
    stby_write(2'b10);
    @(negedge clk);
    chk("R10 shutdown clears", core_valid, 0);
    rst_write(1'b0);
    rst_write(1'b1);
    chk("R10 writes ignored in shutdown", core_valid, 0);

    // R11: wait after leaving shutdown
    us_tick = 1'b1;
    stby_write(2'b00);
    rst_write(1'b0);
    rst_write(1'b1);
    chk("R11 early sequence err", seq_err, 1);
    chk("R11 early sequence invalid", core_valid, 0);
    repeat (110) @(negedge clk);
    rst_write(1'b0);
    rst_write(1'b1);
    chk("R11 late sequence valid", core_valid, 1);
    chk("R11 err sticky", seq_err, 1);
    us_tick = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule